// File: doc/BRIEF.md
# Dual-Channel Pulse-Width Sample Converter

This block is the digital half of a two-channel converter that turns analog quantities into numbers through pulse-width modulation. External comparators compare a voltage signal and a current signal against a shared triangle wave. Each produces a PWM bit stream. Inside the block, one counter per channel counts the system-clock cycles in which its stream is high. This gives one 12-bit sample per channel per conversion frame.

A frame is a fixed window of 2^12 clock cycles, set by a free-running frame counter. At a 25 MHz clock this gives roughly 6 kHz, or about 120 samples per 50 Hz mains cycle. Both channels share the frame, so their samples are taken at the same instant. They are delivered together with one valid strobe.

The frame counter also produces a synchronization output for the external triangle generator. This keeps the analog ramp locked to the digital frame. The samples are offset binary: mid-scale (50 % duty) reads 2048.

Top module: `pwm_sampler`

## Requirements
- R1: A synchronous active-high reset clears both samples to 0, drops the valid strobe and returns the frame position to its start, so that the sync output (square-wave mode) reads 1 in the first cycle after reset.
- R2: A frame lasts exactly 2^12 = 4096 clock cycles. The first valid strobe follows the 4096th rising edge after reset is released, and further strobes come every 4096 cycles.
- R3: Each channel sample equals the number of rising clock edges in the just-finished frame at which that channel's PWM input was high. The two channels are counted independently.
- R4: Counting restarts at every frame boundary, so no high cycle from one frame contributes to the next frame's sample.
- R5: A count that would reach 4096 saturates at 4095.
- R6: The valid strobe is high for exactly one cycle per frame, and both samples take their new values in that same cycle.
- R7: Between strobes both samples hold their values, whatever the PWM inputs do.
- R8: Samples are offset binary: a frame with exactly 2048 high cycles reads 0x800, and a frame with none reads 0x000.
- R9: In the default square-wave mode the triangle-sync output is high during frame positions 0 to 2047 and low during positions 2048 to 4095. Its rising edge therefore marks the start of each frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System (counting) clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_v | input | 1 | PWM stream of the voltage channel |
| pwm_i | input | 1 | PWM stream of the current channel |
| tri_sync | output | 1 | Frame reference for the external triangle generator |
| samp_v | output | 12 | Voltage sample, offset binary |
| samp_i | output | 12 | Current sample, offset binary |
| samp_valid | output | 1 | One-cycle strobe when both samples update |

## Verification
The two channels are driven with different patterns, one per kind of difference:
- Constant levels show the empty frame against the full frame.
- A single pulse whose width sits at the saturation edge (4094, 4095 and 4096 high cycles) shows the saturation limit against plain counting.
- A cycle-by-cycle alternating stream shows that scattered high cycles are summed as well as contiguous ones.
- An all-high frame followed by an all-low frame exposes any count that leaks across the boundary.
- Random duty levels on both channels at once reveal cross-talk between the channels.

A reset in the middle of a frame checks that the frame restarts aligned to the reset.

// File: rtl/pws_pkg.sv
package pws_pkg;

   // Saturating increment: adds one when hit is set, stops at all-ones.
   function automatic logic [31:0] sat_step(input logic [31:0] cur,
                                            input logic        hit,
                                            input logic [31:0] top);
      if (hit && (cur != top))
         return cur + 32'd1;
      return cur;
   endfunction

   // Sync output variants
   localparam int SYNC_SQUARE = 0;
   localparam int SYNC_PULSE  = 1;

endpackage

// File: rtl/pws_frame_timer.sv
module pws_frame_timer #(
   parameter int RES_BITS  = 12,
   parameter int SYNC_MODE = 0
) (
   input  logic clk,
   input  logic rst,
   output logic frame_end,
   output logic frame_valid,
   output logic tri_sync
);
   localparam logic [RES_BITS-1:0] LAST = {RES_BITS{1'b1}};

   logic [RES_BITS-1:0] pos_q;
   logic                vld_q;

   assign frame_end = (pos_q == LAST);

   always_ff @(posedge clk) begin
      if (rst) begin
         pos_q <= '0;
         vld_q <= 1'b0;
      end else begin
         pos_q <= pos_q + 1'b1;
         vld_q <= frame_end;
      end
   end

   assign frame_valid = vld_q;

   generate
      if (SYNC_MODE == pws_pkg::SYNC_PULSE) begin : g_pulse
         logic pls_q;
         always_ff @(posedge clk) begin
            if (rst) pls_q <= 1'b0;
            else     pls_q <= frame_end;
         end
         assign tri_sync = pls_q;
      end else begin : g_square
         assign tri_sync = ~pos_q[RES_BITS-1];
      end
   endgenerate

   AST_FRAME_STEP: assert property (@(posedge clk) disable iff (rst)
      (pos_q != LAST) |=> (pos_q == $past(pos_q) + 1'b1)); // R2

   AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (rst)
      frame_end |=> (pos_q == '0)); // R2

   AST_VALID_AT_START: assert property (@(posedge clk) disable iff (rst)
      vld_q |-> (pos_q == '0)); // R6

endmodule

// File: rtl/pws_width_counter.sv
module pws_width_counter #(
   parameter int RES_BITS    = 12,
   parameter int SYNC_STAGES = 0
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                pwm_in,
   input  logic                frame_end,
   output logic [RES_BITS-1:0] sample
);
   localparam logic [RES_BITS-1:0] TOP = {RES_BITS{1'b1}};

   logic                pwm_s;
   logic [RES_BITS-1:0] cnt_q;
   logic [RES_BITS-1:0] cnt_nx;
   logic [RES_BITS-1:0] smp_q;

   generate
      if (SYNC_STAGES > 0) begin : g_sync
         logic [SYNC_STAGES-1:0] chain_q;
         always_ff @(posedge clk) begin
            if (rst) chain_q <= '0;
            else     chain_q <= {chain_q[SYNC_STAGES-2+1-1:0], pwm_in} >> 0;
         end
         assign pwm_s = chain_q[SYNC_STAGES-1];
      end else begin : g_raw
         assign pwm_s = pwm_in;
      end
   endgenerate

   always_comb begin
      cnt_nx = RES_BITS'(pws_pkg::sat_step(32'(cnt_q), pwm_s, 32'(TOP)));
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
         smp_q <= '0;
      end else if (frame_end) begin
         smp_q <= cnt_nx;
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_nx;
      end
   end

   assign sample = smp_q;

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
      !frame_end |=> (cnt_q >= $past(cnt_q))); // R5

   AST_CLEAR_AT_END: assert property (@(posedge clk) disable iff (rst)
      frame_end |=> (cnt_q == '0)); // R4

   AST_SAMPLE_HOLD: assert property (@(posedge clk) disable iff (rst)
      !frame_end |=> $stable(smp_q)); // R7

endmodule

// File: rtl/pwm_sampler.sv
module pwm_sampler #(
   parameter int RES_BITS    = 12,
   parameter int SYNC_MODE   = 0,
   parameter int SYNC_STAGES = 0
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                pwm_v,
   input  logic                pwm_i,
   output logic                tri_sync,
   output logic [RES_BITS-1:0] samp_v,
   output logic [RES_BITS-1:0] samp_i,
   output logic                samp_valid
);
   localparam int N_CH = 2;

   generate
      if (RES_BITS < 2 || RES_BITS > 24) begin : g_bad_res
         $error("pwm_sampler: RES_BITS out of range");
      end
      if (SYNC_MODE != pws_pkg::SYNC_SQUARE && SYNC_MODE != pws_pkg::SYNC_PULSE) begin : g_bad_mode
         $error("pwm_sampler: unknown SYNC_MODE");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("pwm_sampler: SYNC_STAGES out of range");
      end
   endgenerate

   logic                frame_end;
   logic [N_CH-1:0]     pwm_bus;
   logic [RES_BITS-1:0] smp [N_CH];

   assign pwm_bus = {pwm_i, pwm_v};

   pws_frame_timer #(
      .RES_BITS (RES_BITS),
      .SYNC_MODE(SYNC_MODE)
   ) u_timer (
      .clk        (clk),
      .rst        (rst),
      .frame_end  (frame_end),
      .frame_valid(samp_valid),
      .tri_sync   (tri_sync)
   );

   generate
      for (genvar c = 0; c < N_CH; c++) begin : g_ch
         pws_width_counter #(
            .RES_BITS   (RES_BITS),
            .SYNC_STAGES(SYNC_STAGES)
         ) u_cnt (
            .clk      (clk),
            .rst      (rst),
            .pwm_in   (pwm_bus[c]),
            .frame_end(frame_end),
            .sample   (smp[c])
         );
      end
   endgenerate

   assign samp_v = smp[0];
   assign samp_i = smp[1];

   AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      samp_valid |=> !samp_valid); // R6

   AST_QUIET_BETWEEN: assert property (@(posedge clk) disable iff (rst)
      !frame_end |=> ($stable(samp_v) && $stable(samp_i))); // R7

endmodule

// File: tb/pwm_sampler_bench.sv
`timescale 1ns/1ps
module pwm_sampler_bench;
   localparam int RB   = 12;
   localparam int FLEN = 1 << RB;
   localparam int TOPV = FLEN - 1;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          pwm_v = 1'b0;
   logic          pwm_i = 1'b0;
   logic          tri_sync;
   logic [RB-1:0] samp_v;
   logic [RB-1:0] samp_i;
   logic          samp_valid;

   int n_run  = 0;
   int n_fail = 0;
   int prev_v = 0;
   int prev_i = 0;

   always #10 clk = ~clk;

   pwm_sampler u_pwm_sampler (
      .clk       (clk),
      .rst       (rst),
      .pwm_v     (pwm_v),
      .pwm_i     (pwm_i),
      .tri_sync  (tri_sync),
      .samp_v    (samp_v),
      .samp_i    (samp_i),
      .samp_valid(samp_valid)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // modes: 0 constant, 1 leading pulse of width par, 2 random duty par/4096, 3 alternating
   function automatic bit pat(input int mode, input int par, input int k);
      case (mode)
         0: return par != 0;
         1: return k < par;
         2: return ($urandom % FLEN) < par;
         default: return (k % 2) == 0;
      endcase
   endfunction

   function automatic int sat(input int c);
      return (c > TOPV) ? TOPV : c;
   endfunction

   // Starts at a negedge with frame position 0; ends at the negedge after the frame's last edge.
   task automatic run_frame(input int mv, input int pv, input int mi, input int pi);
      int cv = 0;
      int ci = 0;
      for (int k = 0; k < FLEN; k++) begin
         bit bv;
         bit bi;
         bv = pat(mv, pv, k);
         bi = pat(mi, pi, k);
         pwm_v = bv;
         pwm_i = bi;
         cv += int'(bv);
         ci += int'(bi);
         if (k == 0 || k == 2047 || k == 2048 || k == 4095)
            chk("R9", int'(tri_sync), int'(k < 2048));
         if (k == 1)
            chk("R6", int'(samp_valid), 0);
         if (k == 1000) begin
            chk("R2", int'(samp_valid), 0);
            chk("R7", int'(samp_v), prev_v);
            chk("R7", int'(samp_i), prev_i);
         end
         @(negedge clk);
      end
      chk("R2", int'(samp_valid), 1);
      chk("R3", int'(samp_v), sat(cv));
      chk("R3", int'(samp_i), sat(ci));
      prev_v = sat(cv);
      prev_i = sat(ci);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (5) @(negedge clk);
      chk("R1", int'(samp_v), 0);
      chk("R1", int'(samp_i), 0);
      chk("R1", int'(samp_valid), 0);
      chk("R1", int'(tri_sync), 1);
      rst = 1'b0;

      run_frame(0, 0, 0, 0);
      chk("R8", int'(samp_v), 0);
      run_frame(1, 2048, 1, 2048);
      chk("R8", int'(samp_v), 12'h800);
      chk("R8", int'(samp_i), 12'h800);
      run_frame(0, 1, 0, 1);
      chk("R5", int'(samp_v), 4095);
      run_frame(0, 0, 0, 0);
      chk("R4", int'(samp_v), 0);
      chk("R4", int'(samp_i), 0);
      run_frame(1, 4095, 1, 4094);
      chk("R5", int'(samp_v), 4095);
      chk("R5", int'(samp_i), 4094);
      run_frame(3, 0, 1, 1);
      for (int f = 0; f < 7; f++)
         run_frame(2, int'($urandom % FLEN), 2, int'($urandom % FLEN));

      // mid-frame reset
      for (int k = 0; k < 1500; k++) begin
         pwm_v = 1'b1;
         pwm_i = 1'b1;
         @(negedge clk);
      end
      rst = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1", int'(samp_v), 0);
      chk("R1", int'(samp_i), 0);
      chk("R1", int'(samp_valid), 0);
      chk("R1", int'(tri_sync), 1);
      rst = 1'b0;
      prev_v = 0;
      prev_i = 0;
      run_frame(1, 300, 1, 700);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule